// File: doc/BRIEF.md
# Fan Tachometer Period Monitor

This block measures how fast each of several fans turns by timing one full revolution. Every fan channel sees a tachometer pulse input. The input is brought into the clock domain through a two-stage synchroniser, and only its rising edges are used. Each fan gives two tach pulses per revolution. A revolution therefore starts at one rising edge and ends at the second rising edge after it. Across that window the channel counts ticks of a slow reference enable, which a shared prescaler derives from the system clock. A slow fan gives a large count and a fast fan gives a small count.

The count saturates at the top of its range. A channel whose count reaches full scale before the revolution closes reports the full-scale value and flags the fan as too slow to measure. It then waits for a fresh edge to start again. Each channel also has a programmable limit. A completed count above that limit sets a sticky alarm. Alarms stay set until software clears them through a write-1-to-clear field. A plain register port gives access to the captured counts, the limits and the alarms. The default prescale is chosen so that a 12-bit full scale matches roughly 366 RPM on a 100 MHz clock, which is about 25 kHz of ticks.

Top module: `fan_tach_monitor`

## Requirements
- R1: After reset every captured count reads 0, every limit reads all-ones, every alarm field reads 0 and `alarm_o` is all zero.
- R2: The captured count equals the number of prescaler ticks from the rising edge that opens a revolution up to, but not including, the cycle of the second rising edge after it.
- R3: Revolutions follow one another with no gap: the edge that closes one revolution opens the next, so the captured count updates at the end of every completed revolution, even when the two half-periods differ.
- R4: Alarm bit 0 (over limit) sets when a captured count is strictly greater than that channel's limit. A count equal to the limit does not set it.
- R5: Alarm bits are sticky. Writing a 1 to a bit of the alarm field clears that bit. Writing a 0 leaves it unchanged.
- R6: If the running count reaches all-ones before the revolution closes, the captured count reads all-ones, alarm bit 1 (stall) sets, and the channel waits for a new rising edge to begin measuring.
- R7: Channels are independent. Activity on one fan changes no other channel's count or alarms.
- R8: Register address = channel*4 + field. Field 0 is the count and is read-only, so writes to it are ignored. Field 1 is the limit (read/write). Field 2 is the alarm field (bit 0 over limit, bit 1 stall). Field 3 and channel numbers beyond the last fan read 0.
- R9: `alarm_o[c]` is high exactly while either alarm bit of channel c is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tach_i | input | NUM_FANS | Raw tachometer pulses, one per fan, asynchronous |
| reg_addr | input | ADDR_W | Register address, channel*4 + field |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Read data for reg_addr, combinational |
| alarm_o | output | NUM_FANS | Per-fan alarm summary |

## Verification
The bench builds the block with three fans, an 8-bit count and a prescale of 4. With these values the full-scale stall condition occurs about a thousand cycles after the last edge, so the saturation path can be tested in every scenario. Tach half-periods are chosen as multiples of the prescale, which makes each expected count an exact integer whatever the tick phase. The limit is placed both at a measured count and just below one, which tests both sides of the strict comparison.

// File: rtl/fan_tach_pkg.sv
package fan_tach_pkg;

  // Register field selector, the low two address bits.
  typedef enum logic [1:0] {
    FLD_COUNT = 2'd0,
    FLD_LIMIT = 2'd1,
    FLD_ALARM = 2'd2,
    FLD_RSVD  = 2'd3
  } tach_field_e;

  // Sticky alarm pair; packing order gives bit1 = stall, bit0 = over limit.
  typedef struct packed {
    logic stall;
    logic over_limit;
  } tach_alarm_t;

endpackage

// File: rtl/tach_prescaler.sv
module tach_prescaler #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  generate
    if (DIV > 1) begin : g_div
      localparam int DW = $clog2(DIV);
      logic [DW-1:0] cnt_q;

      always_ff @(posedge clk) begin
        if (!rst_n)                     cnt_q <= '0;
        else if (cnt_q == DW'(DIV - 1)) cnt_q <= '0;
        else                            cnt_q <= cnt_q + 1'b1;
      end

      assign tick_o = (cnt_q == DW'(DIV - 1));

      AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o); // R2
    end else begin : g_pass
      assign tick_o = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/tach_sync.sv
module tach_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o
);
  // Two stages for metastability, a third for the previous value.
  logic [2:0] sh_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[1:0], pin_i};
  end

  assign rise_o = sh_q[1] & ~sh_q[2];
endmodule

// File: rtl/tach_channel.sv
module tach_channel
  import fan_tach_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             rise_i,
  input  logic [CNT_W-1:0] limit_i,
  input  logic [1:0]       clr_i,
  output logic [CNT_W-1:0] count_o,
  output tach_alarm_t      alarm_o
);
  localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};

  logic             armed_q;   // a revolution is being timed
  logic             half_q;    // one mid-revolution edge already seen
  logic [CNT_W-1:0] acc_q;     // running tick count
  logic [CNT_W-1:0] cap_q;     // last captured result
  tach_alarm_t      alm_q;

  logic             cap_ev, stall_ev;
  logic [CNT_W-1:0] acc_inc;

  always_comb begin
    acc_inc  = (acc_q == FULL) ? FULL : acc_q + CNT_W'(tick_i);
    cap_ev   = armed_q && rise_i && half_q;
    stall_ev = armed_q && !rise_i && (acc_q == FULL);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      half_q  <= 1'b0;
      acc_q   <= '0;
      cap_q   <= '0;
    end else if (!armed_q) begin
      if (rise_i) begin
        armed_q <= 1'b1;
        half_q  <= 1'b0;
        acc_q   <= CNT_W'(tick_i);
      end
    end else if (rise_i) begin
      if (half_q) begin
        cap_q  <= acc_q;            // tick of this cycle belongs to next rev
        half_q <= 1'b0;
        acc_q  <= CNT_W'(tick_i);
      end else begin
        half_q <= 1'b1;
        acc_q  <= acc_inc;
      end
    end else if (acc_q == FULL) begin
      cap_q   <= FULL;
      armed_q <= 1'b0;
      half_q  <= 1'b0;
      acc_q   <= '0;
    end else begin
      acc_q <= acc_inc;
    end
  end

  // Sticky alarms: a new event wins over a clear in the same cycle.
  logic over_set;
  assign over_set = (cap_ev && (acc_q > limit_i)) || (stall_ev && (FULL > limit_i));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alm_q <= '0;
    end else begin
      alm_q.over_limit <= over_set | (alm_q.over_limit & ~clr_i[0]);
      alm_q.stall      <= stall_ev | (alm_q.stall & ~clr_i[1]);
    end
  end

  assign count_o = cap_q;
  assign alarm_o = alm_q;

  AST_STALL_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alm_q.stall) |-> (cap_q == FULL)); // R6
  AST_OVER_STRICT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alm_q.over_limit) |-> (cap_q > $past(limit_i))); // R4
  AST_OVER_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (alm_q.over_limit && !clr_i[0]) |=> alm_q.over_limit); // R5
  AST_STALL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (alm_q.stall && !clr_i[1]) |=> alm_q.stall); // R5
endmodule

// File: rtl/fan_tach_monitor.sv
module fan_tach_monitor
  import fan_tach_pkg::*;
#(
  parameter int NUM_FANS = 3,
  parameter int CNT_W    = 12,
  parameter int PRESCALE = 4000,   // ~25 kHz ticks from 100 MHz
  localparam int CH_W    = (NUM_FANS > 1) ? $clog2(NUM_FANS) : 1,
  localparam int ADDR_W  = CH_W + 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_FANS-1:0] tach_i,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic                reg_wr,
  input  logic [CNT_W-1:0]    reg_wdata,
  output logic [CNT_W-1:0]    reg_rdata,
  output logic [NUM_FANS-1:0] alarm_o
);
  logic             tick;
  logic [CNT_W-1:0] cnt_w   [NUM_FANS];
  logic [CNT_W-1:0] limit_q [NUM_FANS];
  tach_alarm_t      alm_w   [NUM_FANS];

  tach_prescaler #(.DIV(PRESCALE)) u_presc (
    .clk(clk), .rst_n(rst_n), .tick_o(tick)
  );

  generate
    for (genvar c = 0; c < NUM_FANS; c++) begin : g_fan
      localparam logic [ADDR_W-1:0] A_LIM = ADDR_W'(c * 4 + 1);
      localparam logic [ADDR_W-1:0] A_ALM = ADDR_W'(c * 4 + 2);
      logic       rise;
      logic [1:0] clr;

      tach_sync u_sync (
        .clk(clk), .rst_n(rst_n), .pin_i(tach_i[c]), .rise_o(rise)
      );

      always_ff @(posedge clk) begin
        if (!rst_n)                            limit_q[c] <= '1;
        else if (reg_wr && reg_addr == A_LIM)  limit_q[c] <= reg_wdata;
      end

      assign clr = (reg_wr && reg_addr == A_ALM) ? reg_wdata[1:0] : 2'b00;

      tach_channel #(.CNT_W(CNT_W)) u_chan (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .rise_i(rise),
        .limit_i(limit_q[c]), .clr_i(clr),
        .count_o(cnt_w[c]), .alarm_o(alm_w[c])
      );

      assign alarm_o[c] = alm_w[c].stall | alm_w[c].over_limit;
    end
  endgenerate

  logic [CH_W-1:0] sel_ch;
  tach_field_e     sel_fld;

  always_comb begin
    sel_ch    = reg_addr[ADDR_W-1:2];
    sel_fld   = tach_field_e'(reg_addr[1:0]);
    reg_rdata = '0;
    if (int'(sel_ch) < NUM_FANS) begin
      case (sel_fld)
        FLD_COUNT: reg_rdata = cnt_w[sel_ch];
        FLD_LIMIT: reg_rdata = limit_q[sel_ch];
        FLD_ALARM: reg_rdata = CNT_W'({alm_w[sel_ch].stall, alm_w[sel_ch].over_limit});
        default:   reg_rdata = '0;
      endcase
    end
  end
endmodule

// File: tb/sim_fan_tach_monitor.sv
module sim_fan_tach_monitor;
  localparam int NF = 3, CW = 8, PS = 4, AW = 4;
  localparam int FULL = (1 << CW) - 1;

  logic          clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0;
  logic [NF-1:0] tach_i = '0;
  logic [AW-1:0] reg_addr = '0;
  logic [CW-1:0] reg_wdata = '0, reg_rdata;
  logic [NF-1:0] alarm_o;

  int vecs = 0, bad = 0;
  bit done = 0;

  typedef struct { int ch; int val; string tag; } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;   // 250 MHz

  fan_tach_monitor #(.NUM_FANS(NF), .CNT_W(CW), .PRESCALE(PS)) u0 (
    .clk(clk), .rst_n(rst_n), .tach_i(tach_i), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .alarm_o(alarm_o)
  );

  task automatic check(input string tag, input int got, input int exp);
    vecs++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); reg_addr = AW'(a); reg_wdata = CW'(d); reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk); reg_addr = AW'(a); #1 v = int'(reg_rdata);
  endtask

  // Driver: rising edges spaced t1, t2 (and t3, t4 for a second revolution).
  task automatic spin(input int ch, input int t1, input int t2,
                      input int t3, input int t4, input string tag);
    int gaps[4] = '{t1, t2, t3, t4};
    int n = (t3 == 0) ? 2 : 4;
    exp_t e;
    e.ch = ch; e.tag = tag;
    e.val = (t3 == 0) ? (t1 + t2) / PS : (t3 + t4) / PS;
    sb.push_back(e);
    @(negedge clk);
    for (int i = 0; i < n; i++) begin
      tach_i[ch] = 1'b1; repeat (2) @(negedge clk);
      tach_i[ch] = 1'b0; repeat (gaps[i] - 2) @(negedge clk);
    end
    tach_i[ch] = 1'b1; repeat (2) @(negedge clk);
    tach_i[ch] = 1'b0;
  endtask

  // Monitor: pop expected results and compare with the count registers.
  task automatic drain();
    int v;
    repeat (10) @(negedge clk);
    while (sb.size() > 0) begin
      exp_t e = sb.pop_front();
      rd(e.ch * 4, v);
      check(e.tag, v, e.val);
    end
  endtask

  task automatic settle();
    repeat (1200) @(negedge clk);
    for (int c = 0; c < NF; c++) wr(c * 4 + 2, 3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int c = 0; c < NF; c++) begin
      rd(c * 4, v);     check("R1 count", v, 0);
      rd(c * 4 + 1, v); check("R1 limit", v, FULL);
      rd(c * 4 + 2, v); check("R1 alarm", v, 0);
    end
    check("R1 alarm_o", int'(alarm_o), 0);

    // R2 R3 R7: three fans at once, ch2 asymmetric halves
    fork
      spin(0, 80, 80, 0, 0, "R2 ch0");
      spin(1, 200, 200, 0, 0, "R7 ch1");
      spin(2, 12, 16, 0, 0, "R3 ch2 asym");
    join
    drain();
    for (int c = 0; c < NF; c++) begin
      rd(c * 4 + 2, v); check("R4 no alarm at full limit", v, 0);
    end

    // R6 stall: no edges, every channel saturates
    repeat (1200) @(negedge clk);
    for (int c = 0; c < NF; c++) begin
      rd(c * 4, v);     check("R6 count full", v, FULL);
      rd(c * 4 + 2, v); check("R6 stall bit", v, 2);
    end
    check("R9 alarm_o all", int'(alarm_o), 7);
    // R8 count field is read-only
    wr(0, 18);
    rd(0, v); check("R8 count ignores write", v, FULL);
    for (int c = 0; c < NF; c++) wr(c * 4 + 2, 2);
    for (int c = 0; c < NF; c++) begin
      rd(c * 4 + 2, v); check("R5 w1c stall", v, 0);
    end
    check("R9 alarm_o clear", int'(alarm_o), 0);

    // R3 back-to-back revolutions: 20 then 30 ticks, last one reported
    spin(0, 40, 40, 60, 60, "R3 second rev");
    drain();
    settle();

    // R4 equal limit does not alarm
    wr(5, 50);
    rd(5, v); check("R8 limit readback", v, 50);
    spin(1, 100, 100, 0, 0, "R4 count at limit");
    drain();
    rd(6, v); check("R4 equal no alarm", v, 0);
    settle();

    // R4 above limit; R5 sticky; R7 R9 per-channel
    spin(1, 104, 104, 0, 0, "R4 count above limit");
    drain();
    rd(6, v); check("R4 over set", v, 1);
    check("R9 alarm_o ch1 only", int'(alarm_o), 2);
    rd(2, v); check("R7 ch0 untouched", v, 0);
    wr(6, 0);
    rd(6, v); check("R5 zero write keeps", v, 1);
    wr(6, 2);
    rd(6, v); check("R5 other bit keeps", v, 1);
    wr(6, 1);
    rd(6, v); check("R5 w1c over", v, 0);

    // R8 unmapped reads
    rd(3, v);  check("R8 field3 zero", v, 0);
    rd(13, v); check("R8 missing channel zero", v, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule